// File: doc/BRIEF.md
# DMA Destination Address Generator

This block produces the destination address for one DMA channel. Software programs a start address, an address-step mode and a reload policy. The channel controller reports each byte it moves and the ends of bursts, blocks and transactions. From these reports the block keeps a current destination address. The address moves by one byte in the chosen direction, or stays put. At the chosen boundary it snaps back to the programmed start value.

Mode, reload and start-address writes are accepted only while the channel is idle. Writes made while the channel is busy are dropped. The block also holds a trigger-select code for the channel. A code of zero turns triggering off. A nonzero code is compared against incoming trigger codes, and on a match the block emits a one-cycle accept pulse.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: The step field sits in bits 1:0 of the control write data. It selects the address behaviour on a byte strobe: 00 holds the address, 01 adds one, 10 subtracts one, and 11 holds the address.
- R2: Incrementing and decrementing wrap modulo 2^ADDR_W (default 24 bits). With the default width, 0xFFFFFF plus one gives 0x000000, and 0x000000 minus one gives 0xFFFFFF.
- R3: The reload field sits in bits 3:2 of the control write data. On a reload the current address is set to the start address. Code 00 never reloads. Code 11 reloads on a transaction end. Code 01 reloads on a block end or a transaction end. Code 10 reloads on a burst end, a block end or a transaction end.
- R4: When a reload and a byte strobe fall in the same cycle, the reload wins and the address becomes the start value.
- R5: A control write while busy_i is high is ignored, so the step and reload settings in force do not change.
- R6: A start-address write while busy_i is low sets both the start value and the current address on the next edge, and it overrides any reload or step in that cycle. A start-address write while busy_i is high is ignored.
- R7: While the trigger-select value is zero, trig_ack_o stays low for every trigger code. The trigger-select value can be written at any time.
- R8: trig_ack_o pulses high one cycle after a cycle in which trig_i is high and trig_code_i equals the nonzero trigger-select value. Otherwise it stays low.
- R9: After reset the address, step, reload and trigger-select fields are all zero, and trig_ack_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Channel busy; locks control and start writes |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control data: reload in bits 3:2, step in bits 1:0 |
| start_we_i | input | 1 | Start address write strobe |
| start_wdata_i | input | ADDR_W | Start address value |
| trig_sel_we_i | input | 1 | Trigger-select write strobe |
| trig_sel_wdata_i | input | TRIG_W | Trigger-select value; zero disables triggering |
| byte_done_i | input | 1 | One byte transferred this cycle |
| burst_end_i | input | 1 | Burst completes this cycle |
| block_end_i | input | 1 | Block completes this cycle |
| txn_end_i | input | 1 | Transaction completes this cycle |
| trig_i | input | 1 | Trigger request valid |
| trig_code_i | input | TRIG_W | Code of the requesting trigger |
| dst_addr_o | output | ADDR_W | Current destination address |
| trig_ack_o | output | 1 | One-cycle trigger accept pulse |

## Verification
A byte strobe and a boundary reload can arrive in the same cycle, and here the reload must win. The bench provokes this collision in two ways. It drives overlapping byte and boundary strobes from a pseudo-random sequence under every step and reload code, and it also forces the collision in directed cases. An arithmetic model of the requirements predicts the address after every edge, so each colliding cycle is judged against the start value. A start-address write on top of a reload is covered the same way.

// File: rtl/dst_addr_pkg.sv
package dst_addr_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_RSVD = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    RLD_OFF   = 2'b00,
    RLD_BLOCK = 2'b01,
    RLD_BURST = 2'b10,
    RLD_TXN   = 2'b11
  } rld_e;

  typedef struct packed {
    rld_e  rld;
    step_e step;
  } ctrl_t;

  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned STEP_LSB = 0;
  localparam int unsigned RLD_MSB  = 3;

endpackage

// File: rtl/dst_cfg_regs.sv
module dst_cfg_regs
  import dst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned TRIG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_wdata_i,
  input  logic              trig_sel_we_i,
  input  logic [TRIG_W-1:0] trig_sel_wdata_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [TRIG_W-1:0] trig_sel_o,
  output logic              start_load_o
);

  logic ctrl_hi_unused;
  assign ctrl_hi_unused = ^ctrl_wdata_i[CTRL_W-1:RLD_MSB+1];

  logic ctrl_acc;
  assign ctrl_acc     = ctrl_we_i && !busy_i;
  assign start_load_o = start_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{rld: RLD_OFF, step: STEP_HOLD};
    end else if (ctrl_acc) begin
      ctrl_o <= ctrl_t'(ctrl_wdata_i[RLD_MSB:STEP_LSB]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
    end else if (start_load_o) begin
      start_o <= start_wdata_i;
    end
  end

  // trigger select is not part of the busy lock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_sel_o <= '0;
    end else if (trig_sel_we_i) begin
      trig_sel_o <= trig_sel_wdata_i;
    end
  end

endmodule

// File: rtl/dst_reload_sel.sv
module dst_reload_sel
  import dst_addr_pkg::*;
(
  input  rld_e rld_i,
  input  logic burst_end_i,
  input  logic block_end_i,
  input  logic txn_end_i,
  output logic reload_o
);

  // boundaries nest: txn end closes a block, block end closes a burst
  logic blk_or_txn;
  logic any_end;
  assign blk_or_txn = block_end_i || txn_end_i;
  assign any_end    = burst_end_i || blk_or_txn;

  always_comb begin
    unique case (rld_i)
      RLD_BLOCK: reload_o = blk_or_txn;
      RLD_BURST: reload_o = any_end;
      RLD_TXN:   reload_o = txn_end_i;
      default:   reload_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dst_addr_step.sv
module dst_addr_step
  import dst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic              byte_done_i,
  input  logic              reload_i,
  input  logic              start_load_i,
  input  logic [ADDR_W-1:0] start_wdata_i,
  input  logic [ADDR_W-1:0] start_q_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (step_i)
      STEP_UP:   stepped = addr_o + ONE;
      STEP_DOWN: stepped = addr_o - ONE;
      default:   stepped = addr_o;
    endcase
  end

  // priority: start write, then reload, then byte step
  always_comb begin
    if (start_load_i)     addr_d = start_wdata_i;
    else if (reload_i)    addr_d = start_q_i;
    else if (byte_done_i) addr_d = stepped;
    else                  addr_d = addr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else         addr_o <= addr_d;
  end

endmodule

// File: rtl/dst_trig_match.sv
module dst_trig_match #(
  parameter int unsigned TRIG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIG_W-1:0] trig_sel_i,
  input  logic              trig_i,
  input  logic [TRIG_W-1:0] trig_code_i,
  output logic              ack_o
);

  logic hit;
  assign hit = trig_i && (trig_sel_i != '0) && (trig_code_i == trig_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= hit;
  end

endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen
  import dst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned TRIG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_wdata_i,
  input  logic              trig_sel_we_i,
  input  logic [TRIG_W-1:0] trig_sel_wdata_i,
  input  logic              byte_done_i,
  input  logic              burst_end_i,
  input  logic              block_end_i,
  input  logic              txn_end_i,
  input  logic              trig_i,
  input  logic [TRIG_W-1:0] trig_code_i,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              trig_ack_o
);

  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] start_q;
  logic [TRIG_W-1:0] trig_sel_q;
  logic              start_load;
  logic              reload;

  dst_cfg_regs #(
    .ADDR_W(ADDR_W),
    .TRIG_W(TRIG_W)
  ) u_cfg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .busy_i          (busy_i),
    .ctrl_we_i       (ctrl_we_i),
    .ctrl_wdata_i    (ctrl_wdata_i),
    .start_we_i      (start_we_i),
    .start_wdata_i   (start_wdata_i),
    .trig_sel_we_i   (trig_sel_we_i),
    .trig_sel_wdata_i(trig_sel_wdata_i),
    .ctrl_o          (ctrl_q),
    .start_o         (start_q),
    .trig_sel_o      (trig_sel_q),
    .start_load_o    (start_load)
  );

  dst_reload_sel u_rld (
    .rld_i      (ctrl_q.rld),
    .burst_end_i(burst_end_i),
    .block_end_i(block_end_i),
    .txn_end_i  (txn_end_i),
    .reload_o   (reload)
  );

  dst_addr_step #(
    .ADDR_W(ADDR_W)
  ) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (ctrl_q.step),
    .byte_done_i  (byte_done_i),
    .reload_i     (reload),
    .start_load_i (start_load),
    .start_wdata_i(start_wdata_i),
    .start_q_i    (start_q),
    .addr_o       (dst_addr_o)
  );

  dst_trig_match #(
    .TRIG_W(TRIG_W)
  ) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_sel_i (trig_sel_q),
    .trig_i     (trig_i),
    .trig_code_i(trig_code_i),
    .ack_o      (trig_ack_o)
  );

endmodule

// File: rtl/dst_addr_gen_chk.sv
module dst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned TRIG_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              start_we_i,
  input logic [ADDR_W-1:0] start_wdata_i,
  input logic              byte_done_i,
  input logic              burst_end_i,
  input logic              block_end_i,
  input logic              txn_end_i,
  input logic              trig_i,
  input logic [TRIG_W-1:0] trig_code_i,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              trig_ack_o,
  input logic [3:0]        ctrl_q,
  input logic [ADDR_W-1:0] start_q,
  input logic [TRIG_W-1:0] trig_sel_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [1:0] step_f;
  logic [1:0] rld_f;
  logic       st_ld;
  logic       plain_byte;
  assign step_f     = ctrl_q[1:0];
  assign rld_f      = ctrl_q[3:2];
  assign st_ld      = start_we_i && !busy_i;
  assign plain_byte = byte_done_i && !burst_end_i && !block_end_i && !txn_end_i && !st_ld;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_byte && (step_f == 2'b00 || step_f == 2'b11) |=> dst_addr_o == $past(dst_addr_o));

  p_up_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_byte && step_f == 2'b01 |=> dst_addr_o == ($past(dst_addr_o) + ONE));

  p_down_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_byte && step_f == 2'b10 |=> dst_addr_o == ($past(dst_addr_o) - ONE));

  p_txn_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_end_i && rld_f != 2'b00 && !st_ld |=> dst_addr_o == $past(start_q));

  p_reload_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i && block_end_i && rld_f == 2'b01 && !st_ld |=> dst_addr_o == $past(start_q));

  p_cfg_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ctrl_q));

  p_start_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ld |=> dst_addr_o == $past(start_wdata_i));

  p_start_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(start_q));

  p_trig_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_sel_q == '0 |=> !trig_ack_o);

  p_trig_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && trig_sel_q != '0 && trig_code_i == trig_sel_q |=> trig_ack_o);

  p_trig_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i || trig_code_i != trig_sel_q |=> !trig_ack_o);

endmodule

bind dma_dst_addr_gen dst_addr_gen_chk #(
  .ADDR_W(ADDR_W),
  .TRIG_W(TRIG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .start_we_i   (start_we_i),
  .start_wdata_i(start_wdata_i),
  .byte_done_i  (byte_done_i),
  .burst_end_i  (burst_end_i),
  .block_end_i  (block_end_i),
  .txn_end_i    (txn_end_i),
  .trig_i       (trig_i),
  .trig_code_i  (trig_code_i),
  .dst_addr_o   (dst_addr_o),
  .trig_ack_o   (trig_ack_o),
  .ctrl_q       (ctrl_q),
  .start_q      (start_q),
  .trig_sel_q   (trig_sel_q)
);

// File: tb/tb_dma_dst_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_dst_addr_gen;

  localparam int AW = 24;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          busy = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_wd = '0;
  logic          start_we = 1'b0;
  logic [AW-1:0] start_wd = '0;
  logic          sel_we = 1'b0;
  logic [TW-1:0] sel_wd = '0;
  logic          byte_s = 1'b0;
  logic          burst_e = 1'b0;
  logic          block_e = 1'b0;
  logic          txn_e = 1'b0;
  logic          trig = 1'b0;
  logic [TW-1:0] trig_code = '0;
  logic [AW-1:0] dst_addr;
  logic          trig_ack;

  always #4 clk = ~clk;

  dma_dst_addr_gen #(.ADDR_W(AW), .TRIG_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .start_we_i(start_we), .start_wdata_i(start_wd),
    .trig_sel_we_i(sel_we), .trig_sel_wdata_i(sel_wd),
    .byte_done_i(byte_s), .burst_end_i(burst_e), .block_end_i(block_e), .txn_end_i(txn_e),
    .trig_i(trig), .trig_code_i(trig_code),
    .dst_addr_o(dst_addr), .trig_ack_o(trig_ack)
  );

  int n_run = 0;
  int n_fail = 0;

  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_step = '0;
  logic [1:0]    m_rld = '0;
  logic [TW-1:0] m_sel = '0;
  logic          m_ack = 1'b0;
  string         cur_tag;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk_addr(input string tag);
    n_run++;
    if (dst_addr !== m_addr) begin
      n_fail++;
      $display("FAIL %s addr act=%h exp=%h", tag, dst_addr, m_addr);
    end
  endtask

  task automatic chk_ack(input string tag);
    n_run++;
    if (trig_ack !== m_ack) begin
      n_fail++;
      $display("FAIL %s ack act=%b exp=%b", tag, trig_ack, m_ack);
    end
  endtask

  // predict the next edge from the driven inputs, then advance to the next negedge
  task automatic tick();
    logic [AW-1:0] nxt;
    logic sl, rl;
    sl = start_we && !busy;
    rl = (m_rld == 2'b01 && (block_e || txn_e)) ||
         (m_rld == 2'b10 && (burst_e || block_e || txn_e)) ||
         (m_rld == 2'b11 && txn_e);
    nxt = m_addr;
    cur_tag = "R1";
    if (sl) begin
      nxt = start_wd; cur_tag = "R6";
    end else if (rl) begin
      nxt = m_start; cur_tag = byte_s ? "R4" : "R3";
    end else if (byte_s) begin
      if (m_step == 2'b01) begin
        nxt = m_addr + 1'b1;
        if (m_addr == '1) cur_tag = "R2";
      end else if (m_step == 2'b10) begin
        nxt = m_addr - 1'b1;
        if (m_addr == '0) cur_tag = "R2";
      end
    end
    m_ack = trig && (m_sel != '0) && (trig_code == m_sel);
    @(negedge clk);
    m_addr = nxt;
    if (sl) m_start = start_wd;
    if (ctrl_we && !busy) {m_rld, m_step} = ctrl_wd[3:0];
    if (sel_we) m_sel = sel_wd;
    ctrl_we = 1'b0; start_we = 1'b0; sel_we = 1'b0;
    byte_s = 1'b0; burst_e = 1'b0; block_e = 1'b0; txn_e = 1'b0; trig = 1'b0;
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog R9 act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] starts [3];
    starts[0] = 24'h000002; starts[1] = 24'hFFFFFD; starts[2] = 24'h123456;

    repeat (3) @(negedge clk);
    chk_addr("R9"); chk_ack("R9");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_addr("R9"); chk_ack("R9");
    // reset fields: fixed step, no reload
    busy = 1'b1; byte_s = 1'b1; txn_e = 1'b1; trig = 1'b1; trig_code = 8'h00;
    tick(); chk_addr("R9"); chk_ack("R9");
    busy = 1'b0;

    // sweep every step and reload code with pseudo-random strobes
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        for (int k = 0; k < 3; k++) begin
          busy = 1'b0;
          ctrl_we = 1'b1; ctrl_wd = {4'hA, r[1:0], s[1:0]};
          tick(); chk_addr("R5");
          start_we = 1'b1; start_wd = starts[k];
          tick(); chk_addr("R6");
          busy = 1'b1;
          for (int c = 0; c < 40; c++) begin
            lfsr_step();
            byte_s  = lfsr[0];
            burst_e = (lfsr[3:1] == 3'd0);
            block_e = (lfsr[7:4] == 4'd0);
            txn_e   = (lfsr[12:8] == 5'd0);
            tick(); chk_addr(cur_tag);
          end
        end
      end
    end

    // wrap both ways
    busy = 1'b0; ctrl_we = 1'b1; ctrl_wd = 8'h01; tick();
    start_we = 1'b1; start_wd = 24'hFFFFFF; tick(); chk_addr("R6");
    busy = 1'b1; byte_s = 1'b1; tick(); chk_addr("R2");
    busy = 1'b0; ctrl_we = 1'b1; ctrl_wd = 8'h02; tick();
    busy = 1'b1; byte_s = 1'b1; tick(); chk_addr("R2");

    // reload beats byte step in the same cycle
    busy = 1'b0; ctrl_we = 1'b1; ctrl_wd = 8'h0D; tick();
    start_we = 1'b1; start_wd = 24'h000040; tick();
    busy = 1'b1; byte_s = 1'b1; tick(); chk_addr("R4");
    byte_s = 1'b1; txn_e = 1'b1; tick(); chk_addr("R4");

    // control and start writes locked while busy
    busy = 1'b0; ctrl_we = 1'b1; ctrl_wd = 8'h01; tick();
    start_we = 1'b1; start_wd = 24'h000100; tick();
    busy = 1'b1; ctrl_we = 1'b1; ctrl_wd = 8'h0E; tick(); chk_addr("R5");
    byte_s = 1'b1; tick(); chk_addr("R5");
    txn_e = 1'b1; tick(); chk_addr("R5");
    start_we = 1'b1; start_wd = 24'h000777; tick(); chk_addr("R6");
    byte_s = 1'b1; tick(); chk_addr("R6");
    busy = 1'b0; ctrl_we = 1'b1; ctrl_wd = 8'h0C; tick();
    busy = 1'b1; txn_e = 1'b1; tick(); chk_addr("R6");
    // start write beats reload when idle
    busy = 1'b0; start_we = 1'b1; start_wd = 24'h00ABCD; txn_e = 1'b1; tick(); chk_addr("R6");

    // trigger compare, every code against several selects
    foreach (starts[i]) ;
    for (int q = 0; q < 4; q++) begin
      busy = q[0];
      sel_we = 1'b1;
      sel_wd = (q == 0) ? 8'h00 : (q == 1) ? 8'h01 : (q == 2) ? 8'h5A : 8'hFF;
      tick(); chk_ack(m_sel == '0 ? "R7" : "R8");
      for (int c = 0; c < 256; c++) begin
        trig = 1'b1; trig_code = c[7:0];
        tick(); chk_ack(m_sel == '0 ? "R7" : "R8");
      end
      trig = 1'b0; trig_code = m_sel;
      tick(); chk_ack("R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule